// File: doc/BRIEF.md
# Shared-Period Multi-Channel PWM With Edge Positions

This block produces up to sixteen pulse-width-modulated outputs that all run on one common period. A prescaler divides the input clock into ticks, and a step counter counts those ticks from zero up to a programmable last step. Each channel holds two step positions: the output goes high when the step counter reaches the rise position and low when it reaches the fall position. The pulse shape is therefore set by where its two edges sit in the period. There is no single compare value.

Software programs the block over a byte-wide register bus with a combinational read port. Channels picked at build time by a mask parameter double-buffer their edge positions. On those channels, writes land in a staging copy. The running copy only takes the staged values at a period boundary that follows a write of the update strobe. A waveform is therefore never changed partway through a period. The other channels use an edge value from the clock after it is written.

Top module: `pwm_edge_gen`

## Requirements
- R1: After reset every register reads 0, both counters are 0 and every output is 0.
- R2: The step counter advances once every prescale+1 clocks and returns to 0 on the tick where it is at or above the last-step value, so a period lasts (prescale+1)*(last_step+1) clocks.
- R3: An enabled output goes high one clock after the step counter equals its rise position and low one clock after it equals its fall position; when both match, low wins (equal positions give 0% duty); with rise below fall the high time is (fall-rise) steps.
- R4: Rise 0 with fall 0xFF keeps an output high for the whole period when last_step is 0xFE or less; with last_step 0xFF it is low for one step per period.
- R5: The enable bits sit at address 0x02 (bit n = channel n, channels 0-7) and 0x03 (bit n = channel 8+n); a channel whose enable is 0 drives 0 from the next clock.
- R6: On a channel whose mask bit is 0, a written edge position is used from the next clock on.
- R7: On a channel whose mask bit is 1, edge writes change only the staged copy; the running positions stay unchanged until a commit.
- R8: Writing a byte with bit 0 set to address 0x04 makes a commit pending; at the next tick that wraps the step counter, all masked channels load their staged positions and the pending flag clears; bit 0 of address 0x04 reads the pending flag; a write with bit 0 clear does nothing.
- R9: Every register reads back its last written value (staged values for masked channels); unmapped addresses read 0.
- R10: Address map: 0x00 prescale, 0x01 last step, 0x10+n rise position of channel n, 0x20+n fall position of channel n.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_addr | input | 6 | Register address for reads and writes |
| bus_wr | input | 1 | Write strobe, one write per clock |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data for bus_addr, combinational |
| pwm_out | output | NUM_CH | Channel outputs |

## Verification
The hardest case to reach is a commit that meets the period boundary in an awkward way. This includes strobes written while a commit is already pending, staged writes landing in the boundary cycle itself, and last-step values lowered below the current step count. The stimulus reaches these by issuing random staged writes and strobes throughout each random phase, and the phases use short periods so that boundaries come often. A cycle-level bench model checks every output on every clock. Directed runs measure the period length, full duty at last steps 0xFE and 0xFF, equal edge positions, and the staged-versus-running behaviour of one masked channel.

// File: rtl/pwm_edge_pkg.sv
package pwm_edge_pkg;

    localparam int BYTE_W = 8;
    localparam int MAX_CH = 16;
    localparam int ADDR_W = 6;

    localparam logic [ADDR_W-1:0] A_PRESCALE = 6'h00;
    localparam logic [ADDR_W-1:0] A_LAST     = 6'h01;
    localparam logic [ADDR_W-1:0] A_EN_LO    = 6'h02;
    localparam logic [ADDR_W-1:0] A_EN_HI    = 6'h03;
    localparam logic [ADDR_W-1:0] A_COMMIT   = 6'h04;

    typedef logic [BYTE_W-1:0] step_t;

    typedef struct packed {
        step_t rise;
        step_t fall;
    } edge_pair_t;

    typedef struct packed {
        step_t prescale;
        step_t last_step;
    } timebase_cfg_t;

    typedef enum logic [2:0] {
        RK_NONE,
        RK_PRESCALE,
        RK_LAST,
        RK_EN_LO,
        RK_EN_HI,
        RK_COMMIT,
        RK_RISE,
        RK_FALL
    } reg_kind_e;

    typedef struct packed {
        reg_kind_e   kind;
        logic [3:0]  ch;
    } reg_sel_t;

    // Address decode; channel slots beyond the built count decode to nothing.
    function automatic reg_sel_t decode_addr(logic [ADDR_W-1:0] a, int nch);
        reg_sel_t s;
        s.kind = RK_NONE;
        s.ch   = a[3:0];
        case (a[5:4])
            2'b00: begin
                case (a[3:0])
                    4'h0:    s.kind = RK_PRESCALE;
                    4'h1:    s.kind = RK_LAST;
                    4'h2:    s.kind = RK_EN_LO;
                    4'h3:    s.kind = RK_EN_HI;
                    4'h4:    s.kind = RK_COMMIT;
                    default: s.kind = RK_NONE;
                endcase
            end
            2'b01:   if (int'(a[3:0]) < nch) s.kind = RK_RISE;
            2'b10:   if (int'(a[3:0]) < nch) s.kind = RK_FALL;
            default: s.kind = RK_NONE;
        endcase
        return s;
    endfunction

    // Next output level: disabled forces low, a fall match beats a rise match.
    function automatic logic next_level(logic cur, logic en, step_t step, edge_pair_t e);
        if (!en)             return 1'b0;
        if (step == e.fall)  return 1'b0;
        if (step == e.rise)  return 1'b1;
        return cur;
    endfunction

endpackage

// File: rtl/pwm_edge_timebase.sv
module pwm_edge_timebase
    import pwm_edge_pkg::*;
(
    input  logic          clk,
    input  logic          rst,
    input  timebase_cfg_t cfg,
    output step_t         step,
    output logic          tick,
    output logic          period_end
);

    step_t pre_cnt;
    step_t step_q;

    // ">=" so that lowering a limit below a running count still wraps at once
    assign tick       = (pre_cnt >= cfg.prescale);
    assign period_end = tick && (step_q >= cfg.last_step);
    assign step       = step_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            pre_cnt <= '0;
            step_q  <= '0;
        end else begin
            pre_cnt <= tick ? '0 : pre_cnt + 8'd1;
            if (tick) begin
                step_q <= period_end ? '0 : step_q + 8'd1;
            end
        end
    end

endmodule

// File: rtl/pwm_edge_channel.sv
module pwm_edge_channel
    import pwm_edge_pkg::*;
(
    input  logic       clk,
    input  logic       rst,
    input  logic       en,
    input  step_t      step,
    input  edge_pair_t edges,
    output logic       out
);

    logic out_q;

    always_ff @(posedge clk) begin
        if (rst) begin
            out_q <= 1'b0;
        end else begin
            out_q <= next_level(out_q, en, step, edges);
        end
    end

    assign out = out_q;

endmodule

// File: rtl/pwm_edge_regs.sv
module pwm_edge_regs
    import pwm_edge_pkg::*;
#(
    parameter int          NUM_CH    = 16,
    parameter logic [15:0] SYNC_MASK = 16'h0F0F
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic [ADDR_W-1:0]         addr,
    input  logic                      wr,
    input  logic [BYTE_W-1:0]         wdata,
    input  logic                      period_end,
    output timebase_cfg_t             cfg,
    output logic [NUM_CH-1:0]         en,
    output edge_pair_t [NUM_CH-1:0]   act,
    output logic                      commit_pending,
    output logic [BYTE_W-1:0]         rdata
);

    reg_sel_t sel;
    assign sel = decode_addr(addr, NUM_CH);

    timebase_cfg_t           cfg_q;
    logic [NUM_CH-1:0]       en_q;
    logic [MAX_CH-1:0]       en_ext;
    logic [MAX_CH-1:0]       en_wr;
    logic                    pend_q;
    logic                    commit_now;
    edge_pair_t [NUM_CH-1:0] prog_v;

    assign en_ext     = MAX_CH'(en_q);
    assign commit_now = period_end && pend_q;

    always_comb begin
        en_wr = en_ext;
        if (wr && sel.kind == RK_EN_LO) en_wr[7:0]  = wdata;
        if (wr && sel.kind == RK_EN_HI) en_wr[15:8] = wdata;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            cfg_q  <= '0;
            en_q   <= '0;
            pend_q <= 1'b0;
        end else begin
            if (wr && sel.kind == RK_PRESCALE) cfg_q.prescale  <= wdata;
            if (wr && sel.kind == RK_LAST)     cfg_q.last_step <= wdata;
            en_q <= en_wr[NUM_CH-1:0];
            // a strobe in the boundary cycle waits for the following boundary
            if (wr && sel.kind == RK_COMMIT && wdata[0]) begin
                pend_q <= 1'b1;
            end else if (period_end) begin
                pend_q <= 1'b0;
            end
        end
    end

    for (genvar i = 0; i < NUM_CH; i++) begin : g_ch
        logic       hit_ch;
        edge_pair_t prog_q;

        assign hit_ch    = wr && (sel.ch == 4'(i));
        assign prog_v[i] = prog_q;

        always_ff @(posedge clk) begin
            if (rst) begin
                prog_q <= '0;
            end else begin
                if (hit_ch && sel.kind == RK_RISE) prog_q.rise <= wdata;
                if (hit_ch && sel.kind == RK_FALL) prog_q.fall <= wdata;
            end
        end

        if (SYNC_MASK[i]) begin : g_staged
            edge_pair_t run_q;
            always_ff @(posedge clk) begin
                if (rst) begin
                    run_q <= '0;
                end else if (commit_now) begin
                    run_q <= prog_q;
                end
            end
            assign act[i] = run_q;
        end else begin : g_direct
            assign act[i] = prog_q;
        end
    end

    always_comb begin
        case (sel.kind)
            RK_PRESCALE: rdata = cfg_q.prescale;
            RK_LAST:     rdata = cfg_q.last_step;
            RK_EN_LO:    rdata = en_ext[7:0];
            RK_EN_HI:    rdata = en_ext[15:8];
            RK_COMMIT:   rdata = {7'd0, pend_q};
            RK_RISE:     rdata = prog_v[sel.ch].rise;
            RK_FALL:     rdata = prog_v[sel.ch].fall;
            default:     rdata = '0;
        endcase
    end

    assign cfg            = cfg_q;
    assign en             = en_q;
    assign commit_pending = pend_q;

endmodule

// File: rtl/pwm_edge_gen.sv
module pwm_edge_gen
    import pwm_edge_pkg::*;
#(
    parameter int          NUM_CH    = 16,
    parameter logic [15:0] SYNC_MASK = 16'h0F0F
) (
    input  logic              clk,
    input  logic              rst,
    input  logic [5:0]        bus_addr,
    input  logic              bus_wr,
    input  logic [7:0]        bus_wdata,
    output logic [7:0]        bus_rdata,
    output logic [NUM_CH-1:0] pwm_out
);

    timebase_cfg_t           cfg;
    step_t                   step;
    logic                    tick;
    logic                    period_end;
    logic [NUM_CH-1:0]       en;
    edge_pair_t [NUM_CH-1:0] act;
    logic                    commit_pending;

    pwm_edge_timebase u_timebase (
        .clk        (clk),
        .rst        (rst),
        .cfg        (cfg),
        .step       (step),
        .tick       (tick),
        .period_end (period_end)
    );

    pwm_edge_regs #(
        .NUM_CH    (NUM_CH),
        .SYNC_MASK (SYNC_MASK)
    ) u_regs (
        .clk            (clk),
        .rst            (rst),
        .addr           (bus_addr),
        .wr             (bus_wr),
        .wdata          (bus_wdata),
        .period_end     (period_end),
        .cfg            (cfg),
        .en             (en),
        .act            (act),
        .commit_pending (commit_pending),
        .rdata          (bus_rdata)
    );

    for (genvar i = 0; i < NUM_CH; i++) begin : g_out
        pwm_edge_channel u_channel (
            .clk   (clk),
            .rst   (rst),
            .en    (en[i]),
            .step  (step),
            .edges (act[i]),
            .out   (pwm_out[i])
        );
    end

endmodule

// File: rtl/pwm_edge_gen_chk.sv
module pwm_edge_gen_chk
    import pwm_edge_pkg::*;
#(
    parameter int          NUM_CH    = 16,
    parameter logic [15:0] SYNC_MASK = 16'h0F0F
) (
    input logic                    clk,
    input logic                    rst,
    input logic [5:0]              bus_addr,
    input logic                    bus_wr,
    input logic [7:0]              bus_wdata,
    input logic [7:0]              bus_rdata,
    input logic [NUM_CH-1:0]       pwm_out,
    input step_t                   step,
    input logic                    tick,
    input logic                    period_end,
    input logic [NUM_CH-1:0]       en,
    input edge_pair_t [NUM_CH-1:0] act,
    input logic                    commit_pending
);

    logic strobe;
    assign strobe = bus_wr && (bus_addr == A_COMMIT) && bus_wdata[0];

    a_r2_step_holds: assert property (@(posedge clk) disable iff (rst)
        !tick |=> $stable(step));

    a_r2_step_wraps: assert property (@(posedge clk) disable iff (rst)
        period_end |=> (step == 8'd0));

    a_r2_step_advances: assert property (@(posedge clk) disable iff (rst)
        (tick && !period_end) |=> (step == $past(step) + 8'd1));

    a_r5_disabled_low: assert property (@(posedge clk) disable iff (rst)
        (~en != '0) |=> ((pwm_out & ~$past(en)) == '0));

    a_r8_pending_clears: assert property (@(posedge clk) disable iff (rst)
        (period_end && commit_pending && !strobe) |=> !commit_pending);

    a_r8_strobe_sets: assert property (@(posedge clk) disable iff (rst)
        strobe |=> commit_pending);

    a_r8_pending_reads: assert property (@(posedge clk) disable iff (rst)
        (bus_addr == A_COMMIT) |-> (bus_rdata[0] == commit_pending));

    for (genvar i = 0; i < NUM_CH; i++) begin : g_chk
        a_r3_equal_edges_low: assert property (@(posedge clk) disable iff (rst)
            (en[i] && step == act[i].rise && step == act[i].fall) |=> !pwm_out[i]);

        if (SYNC_MASK[i]) begin : g_staged
            a_r7_running_holds: assert property (@(posedge clk) disable iff (rst)
                !(period_end && commit_pending) |=> $stable(act[i]));
        end
    end

endmodule

bind pwm_edge_gen pwm_edge_gen_chk #(
    .NUM_CH    (NUM_CH),
    .SYNC_MASK (SYNC_MASK)
) u_chk (
    .clk            (clk),
    .rst            (rst),
    .bus_addr       (bus_addr),
    .bus_wr         (bus_wr),
    .bus_wdata      (bus_wdata),
    .bus_rdata      (bus_rdata),
    .pwm_out        (pwm_out),
    .step           (step),
    .tick           (tick),
    .period_end     (period_end),
    .en             (en),
    .act            (act),
    .commit_pending (commit_pending)
);

// File: tb/test_pwm_edge_gen.sv
module test_pwm_edge_gen;

    localparam int          NCH  = 16;
    localparam logic [15:0] MASK = 16'h0F0F;

    logic           clk = 1'b0;
    logic           rst = 1'b1;
    logic [5:0]     bus_addr = '0;
    logic           bus_wr = 1'b0;
    logic [7:0]     bus_wdata = '0;
    logic [7:0]     bus_rdata;
    logic [NCH-1:0] pwm_out;

    always #4 clk = ~clk;

    pwm_edge_gen #(.NUM_CH(NCH), .SYNC_MASK(MASK)) i_pwm_edge_gen (
        .clk(clk), .rst(rst), .bus_addr(bus_addr), .bus_wr(bus_wr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .pwm_out(pwm_out)
    );

    int    total = 0;
    int    bad = 0;
    int    shown = 0;
    logic  cmp_on = 1'b0;
    string cmp_tag = "R3";

    // ---------------- bench model built from the requirements ----------------
    int         m_pc, m_step;
    logic [7:0] m_pre, m_last;
    logic [15:0] m_en, m_out;
    logic [7:0] m_rise_a [NCH];
    logic [7:0] m_fall_a [NCH];
    logic [7:0] m_rise_s [NCH];
    logic [7:0] m_fall_s [NCH];
    logic       m_pend;

    always @(posedge clk) begin : model
        logic tk, pe;
        logic [15:0] nx;
        if (rst) begin
            m_pc = 0; m_step = 0; m_pre = 0; m_last = 0; m_en = 0; m_out = 0; m_pend = 0;
            for (int c = 0; c < NCH; c++) begin
                m_rise_a[c] = 0; m_fall_a[c] = 0; m_rise_s[c] = 0; m_fall_s[c] = 0;
            end
        end else begin
            tk = (m_pc >= int'(m_pre));
            pe = tk && (m_step >= int'(m_last));
            for (int c = 0; c < NCH; c++) begin
                if (!m_en[c])                          nx[c] = 1'b0;
                else if (m_step == int'(m_fall_a[c]))  nx[c] = 1'b0;
                else if (m_step == int'(m_rise_a[c]))  nx[c] = 1'b1;
                else                                   nx[c] = m_out[c];
            end
            if (pe && m_pend) begin
                for (int c = 0; c < NCH; c++) begin
                    if (MASK[c]) begin
                        m_rise_a[c] = m_rise_s[c];
                        m_fall_a[c] = m_fall_s[c];
                    end
                end
            end
            if (bus_wr) begin
                case (bus_addr)
                    6'h00: m_pre = bus_wdata;
                    6'h01: m_last = bus_wdata;
                    6'h02: m_en[7:0] = bus_wdata;
                    6'h03: m_en[15:8] = bus_wdata;
                    default: begin
                        if (bus_addr[5:4] == 2'b01) begin
                            m_rise_s[bus_addr[3:0]] = bus_wdata;
                            if (!MASK[bus_addr[3:0]]) m_rise_a[bus_addr[3:0]] = bus_wdata;
                        end else if (bus_addr[5:4] == 2'b10) begin
                            m_fall_s[bus_addr[3:0]] = bus_wdata;
                            if (!MASK[bus_addr[3:0]]) m_fall_a[bus_addr[3:0]] = bus_wdata;
                        end
                    end
                endcase
            end
            if (bus_wr && bus_addr == 6'h04 && bus_wdata[0]) m_pend = 1'b1;
            else if (pe) m_pend = 1'b0;
            m_pc   = tk ? 0 : m_pc + 1;
            m_step = tk ? (pe ? 0 : m_step + 1) : m_step;
            m_out  = nx;
        end
    end

    function automatic logic [7:0] exp_rd(logic [5:0] a);
        case (a)
            6'h00: return m_pre;
            6'h01: return m_last;
            6'h02: return m_en[7:0];
            6'h03: return m_en[15:8];
            6'h04: return {7'd0, m_pend};
            default: begin
                if (a[5:4] == 2'b01) return m_rise_s[a[3:0]];
                if (a[5:4] == 2'b10) return m_fall_s[a[3:0]];
                return 8'h00;
            end
        endcase
    endfunction

    // ---------------- checking helpers ----------------
    task automatic check(input string tag, input logic [31:0] got, input logic [31:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s: got %0h expected %0h at %0t", tag, got, exp, $time);
        end
    endtask

    always @(negedge clk) begin
        if (cmp_on && !rst) begin
            total++;
            if (pwm_out !== m_out) begin
                bad++;
                if (shown < 10) begin
                    shown++;
                    $display("FAIL %s: pwm_out got %h expected %h at %0t", cmp_tag, pwm_out, m_out, $time);
                end
            end
        end
    end

    task automatic wr_reg(input logic [5:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_addr = a; bus_wr = 1'b1; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd_check(input string tag, input logic [5:0] a);
        bus_addr = a;
        #1;
        check(tag, bus_rdata, exp_rd(a));
    endtask

    task automatic count_high(input int ch, input int n, output int hi);
        hi = 0;
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            if (pwm_out[ch]) hi++;
        end
    endtask

    task automatic wait_rise(input int ch);
        logic prev;
        @(negedge clk);
        prev = pwm_out[ch];
        for (int k = 0; k < 2000; k++) begin
            @(negedge clk);
            if (pwm_out[ch] && !prev) break;
            prev = pwm_out[ch];
        end
    endtask

    task automatic finish_run();
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: got timeout expected completion");
        finish_run();
    end

    // ---------------- stimulus ----------------
    initial begin
        int hi, t0, t1;
        void'($urandom(32'h5eed_1234));
        repeat (4) @(negedge clk);
        rst = 1'b0;
        cmp_on = 1'b1;

        // R1: reset state
        check("R1 outputs", pwm_out, 0);
        for (int a = 0; a < 5; a++) begin
            bus_addr = 6'(a); #1; check("R1 register", bus_rdata, 0);
        end
        bus_addr = 6'h13; #1; check("R1 rise", bus_rdata, 0);
        bus_addr = 6'h2C; #1; check("R1 fall", bus_rdata, 0);

        // R9, R10: readback of every register
        wr_reg(6'h00, 8'h03);
        wr_reg(6'h01, 8'h21);
        for (int c = 0; c < NCH; c++) begin
            wr_reg(6'(6'h10 + c), 8'($urandom));
            wr_reg(6'(6'h20 + c), 8'($urandom));
        end
        wr_reg(6'h02, 8'h00);
        wr_reg(6'h03, 8'h00);
        rd_check("R10 prescale", 6'h00);
        check("R10 prescale value", bus_rdata, 8'h03);
        rd_check("R10 last step", 6'h01);
        check("R10 last step value", bus_rdata, 8'h21);
        for (int c = 0; c < NCH; c++) begin
            rd_check("R9 rise readback", 6'(6'h10 + c));
            rd_check("R9 fall readback", 6'(6'h20 + c));
        end
        bus_addr = 6'h05; #1; check("R9 unmapped", bus_rdata, 0);
        bus_addr = 6'h3F; #1; check("R9 unmapped", bus_rdata, 0);

        // R3 R5 R6 R7 R8: random phases against the model
        cmp_tag = "R3/R5/R6/R7/R8 random";
        for (int ph = 0; ph < 24; ph++) begin
            int per, len;
            wr_reg(6'h00, 8'($urandom % 3));
            wr_reg(6'h01, 8'(3 + $urandom % 28));
            per = 34;
            for (int c = 0; c < NCH; c++) begin
                wr_reg(6'(6'h10 + c), 8'($urandom % per));
                wr_reg(6'(6'h20 + c), 8'($urandom % per));
            end
            wr_reg(6'h02, 8'($urandom));
            wr_reg(6'h03, 8'($urandom));
            wr_reg(6'h04, 8'h01);
            len = 300;
            for (int k = 0; k < len; k++) begin
                int r;
                r = int'($urandom % 16);
                if (r == 0) wr_reg(6'(6'h10 + $urandom % 16), 8'($urandom % per));
                else if (r == 1) wr_reg(6'(6'h20 + $urandom % 16), 8'($urandom % per));
                else if (r == 2) wr_reg(6'h04, 8'($urandom % 2));
                else if (r == 3) begin rd_check("R8 pending readback", 6'h04); @(negedge clk); end
                else if (r == 4 && ph % 4 == 3) wr_reg(6'h01, 8'(2 + $urandom % 10));
                else @(negedge clk);
            end
        end

        // R2: period length and high time on direct channel 4
        cmp_tag = "R2/R3 directed";
        wr_reg(6'h02, 8'h00); wr_reg(6'h03, 8'h00);
        wr_reg(6'h00, 8'd2); wr_reg(6'h01, 8'd9);
        wr_reg(6'h14, 8'd0); wr_reg(6'h24, 8'd5);
        wr_reg(6'h02, 8'h10);
        wait_rise(4); t0 = $time;
        wait_rise(4); t1 = $time;
        check("R2 period clocks", (t1 - t0) / 8, 30);
        count_high(4, 30, hi);
        check("R3 high clocks", hi, 15);

        // R3: equal positions give 0% duty
        wr_reg(6'h15, 8'd3); wr_reg(6'h25, 8'd3); wr_reg(6'h02, 8'h20);
        count_high(5, 90, hi);
        check("R3 equal edges", hi, 0);

        // R4: full duty reachable only below 0xFF
        wr_reg(6'h00, 8'd0); wr_reg(6'h01, 8'hFE);
        wr_reg(6'h14, 8'h00); wr_reg(6'h24, 8'hFF); wr_reg(6'h02, 8'h10);
        repeat (300) @(negedge clk);
        count_high(4, 510, hi);
        check("R4 full duty at FE", hi, 510);
        wr_reg(6'h01, 8'hFF);
        repeat (300) @(negedge clk);
        count_high(4, 512, hi);
        check("R4 one low step at FF", hi, 510);

        // R5: low-byte enables cleared, high byte bit 0 sets channel 8
        wr_reg(6'h02, 8'h00); wr_reg(6'h03, 8'h01);
        rd_check("R5 enable high byte", 6'h03);
        check("R5 enable high value", bus_rdata, 8'h01);
        count_high(4, 40, hi);
        check("R5 disabled channel low", hi, 0);

        // R7, R8: staged channel 0
        cmp_tag = "R7/R8 directed";
        wr_reg(6'h00, 8'd1); wr_reg(6'h01, 8'd19);
        wr_reg(6'h10, 8'd2); wr_reg(6'h20, 8'd10);
        wr_reg(6'h04, 8'h01);
        wr_reg(6'h02, 8'h01);
        repeat (100) @(negedge clk);
        rd_check("R8 pending cleared", 6'h04);
        check("R8 pending value", bus_rdata, 0);
        wr_reg(6'h10, 8'd5); wr_reg(6'h20, 8'd15);
        count_high(0, 80, hi);
        check("R7 running kept", hi, 32);
        rd_check("R9 staged rise", 6'h10);
        check("R9 staged rise value", bus_rdata, 8'd5);
        wr_reg(6'h04, 8'h00);
        rd_check("R8 bit0 clear ignored", 6'h04);
        check("R8 bit0 clear value", bus_rdata, 0);
        wr_reg(6'h04, 8'h01);
        rd_check("R8 pending set", 6'h04);
        check("R8 pending value", bus_rdata, 1);
        repeat (45) @(negedge clk);
        rd_check("R8 pending cleared at boundary", 6'h04);
        check("R8 cleared value", bus_rdata, 0);
        count_high(0, 80, hi);
        check("R7 staged committed", hi, 40);

        // R6: direct channel 6 uses a new fall at once
        cmp_tag = "R6 directed";
        wr_reg(6'h16, 8'd0); wr_reg(6'h26, 8'd30); wr_reg(6'h02, 8'h40);
        repeat (80) @(negedge clk);
        count_high(6, 40, hi);
        check("R6 full high", hi, 40);
        wr_reg(6'h26, 8'd4);
        repeat (40) @(negedge clk);
        count_high(6, 40, hi);
        check("R6 new fall used", hi, 8);

        finish_run();
    end

endmodule